// File: doc/BRIEF.md
# Quadrature Flash-Sample Capture with One-Hot Conversion

This block sits behind a bank of flash comparators in a sampled amplitude receiver. The comparators deliver a thermometer code of six bits for seven levels. Two guard comparators, one past each end of the range, tell whether the input left that range. Each carrier period the block captures the code twice. The first capture is on a sine-phase enable and feeds stream A. The second is on a cosine-phase enable that falls a quarter period later and feeds stream B. Both enables live in one fast clock domain.

Each capture is turned into a seven-bit one-hot level by XORing neighbouring bits of the code. The code is padded with an implied 1 below its lowest bit and an implied 0 above its highest bit, so all seven positions come out of the XOR. Level k stands for the signed sample k-3. Each stream presents its level on a registered output with a one-cycle valid pulse. A sticky out-of-range flag records any capture taken while a guard showed the input outside the range. There is no binary encoder: downstream logic consumes the one-hot levels directly.

Top module: `quad_thermo_sampler`

## Requirements
- R1: A legal thermometer input with its lowest n bits set (n = 0..6, bit 0 being the lowest comparator) yields a one-hot output with only bit n set; bit n stands for the signed value n-3.
- R2: On a clock edge where `sin_en` is high, `thermo_in` is captured into `a_level`, and `a_valid` is high for exactly the one cycle that follows that edge.
- R3: On a clock edge where `cos_en` is high, `thermo_in` is captured into `b_level` with a one-cycle `b_valid` pulse. This is independent of stream A, and both may capture on the same edge.
- R4: Between captures each stream holds its last level unchanged, and its valid stays low.
- R5: After synchronous reset, both levels read 7'b0001000 (level 3, value zero), both valids are low, and `range_err` is low.
- R6: A non-thermometer input gives output bit k = t[k] XOR t[k-1], with t[-1] taken as 1 and t[6] taken as 0; the result may then have zero or several bits set.
- R7: A capture edge (either enable high) where `guard_hi` is 1 or `guard_lo` is 0 sets `range_err`; the flag is visible in the following cycle.
- R8: `range_err` stays set until an edge with `err_clr` high, which clears it for the following cycle. When a new out-of-range capture coincides with `err_clr`, the flag stays set.
- R9: Guard inputs on edges where neither enable is high do not affect `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| thermo_in | input | 6 | Thermometer code from the in-range comparators, bit 0 lowest |
| guard_lo | input | 1 | Bottom guard comparator, 0 when the input is below the range |
| guard_hi | input | 1 | Top guard comparator, 1 when the input is above the range |
| sin_en | input | 1 | Sine-phase capture enable, stream A |
| cos_en | input | 1 | Cosine-phase capture enable, stream B |
| err_clr | input | 1 | Clears the sticky out-of-range flag |
| a_level | output | 7 | One-hot level of stream A |
| a_valid | output | 1 | One-cycle pulse after an A capture |
| b_level | output | 7 | One-hot level of stream B |
| b_valid | output | 1 | One-cycle pulse after a B capture |
| range_err | output | 1 | Sticky out-of-range flag |

## Verification
The extreme codes matter most: all zeros must give bit 0 and all ones must give bit 6. A converter that dropped either pad bit would lose one of those levels or report two. Bubbled codes are checked bit by bit, because a design that forced a single hot bit would hide the corruption that downstream self-clearing logic relies on seeing. Cycles with both enables high, or with neither, expose a design that swapped or shared the stream registers, or that re-pulsed a valid. The flag is checked when a clear meets a fresh out-of-range capture, and when the guards toggle with no enable high. A design that gave the clear priority, or that watched the guards every cycle, would report the wrong flag there.

// File: rtl/qts_pkg.sv
package qts_pkg;
  parameter int unsigned DEF_CMP_W = 6;

  typedef struct packed {
    logic above;
    logic below;
  } guard_t;
endpackage

// File: rtl/qts_thermo2onehot.sv
module qts_thermo2onehot #(
  parameter int unsigned CMP_W = 6,
  localparam int unsigned LVL = CMP_W + 1
) (
  input  logic [CMP_W-1:0] thermo,
  output logic [LVL-1:0]   onehot
);
  logic [CMP_W+1:0] padded;

  assign padded = {1'b0, thermo, 1'b1};

  genvar k;
  generate
    for (k = 0; k < LVL; k++) begin : g_lvl
      assign onehot[k] = padded[k] ^ padded[k+1];
    end
  endgenerate
endmodule

// File: rtl/qts_phase_capture.sv
module qts_phase_capture #(
  parameter int unsigned LVL = 7,
  localparam int unsigned MID = (LVL - 1) / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [LVL-1:0] d,
  output logic [LVL-1:0] q,
  output logic           vld
);
  localparam logic [LVL-1:0] RESET_LVL = LVL'(1) << MID;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RESET_LVL;
      vld <= 1'b0;
    end else begin
      vld <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/qts_range_monitor.sv
module qts_range_monitor
  import qts_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   capture,
  input  guard_t guard,
  input  logic   clr,
  output logic   flag
);
  logic hit;

  assign hit = capture && (guard.above || guard.below);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/quad_thermo_sampler.sv
module quad_thermo_sampler
  import qts_pkg::*;
#(
  parameter int unsigned CMP_W = DEF_CMP_W,
  localparam int unsigned LVL = CMP_W + 1,
  localparam int unsigned NPH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] thermo_in,
  input  logic             guard_lo,
  input  logic             guard_hi,
  input  logic             sin_en,
  input  logic             cos_en,
  input  logic             err_clr,
  output logic [LVL-1:0]   a_level,
  output logic             a_valid,
  output logic [LVL-1:0]   b_level,
  output logic             b_valid,
  output logic             range_err
);
  logic [LVL-1:0] conv;
  logic [NPH-1:0] ph_en;
  logic [LVL-1:0] ph_q   [NPH];
  logic [NPH-1:0] ph_vld;
  guard_t         gstat;

  qts_thermo2onehot #(.CMP_W(CMP_W)) u_conv (
    .thermo (thermo_in),
    .onehot (conv)
  );

  assign ph_en = {cos_en, sin_en};

  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_phase
      qts_phase_capture #(.LVL(LVL)) u_cap (
        .clk (clk),
        .rst (rst),
        .en  (ph_en[p]),
        .d   (conv),
        .q   (ph_q[p]),
        .vld (ph_vld[p])
      );
    end
  endgenerate

  assign a_level = ph_q[0];
  assign a_valid = ph_vld[0];
  assign b_level = ph_q[1];
  assign b_valid = ph_vld[1];

  assign gstat.above = guard_hi;
  assign gstat.below = ~guard_lo;

  qts_range_monitor u_range (
    .clk     (clk),
    .rst     (rst),
    .capture (sin_en | cos_en),
    .guard   (gstat),
    .clr     (err_clr),
    .flag    (range_err)
  );
endmodule

// File: rtl/qts_checker.sv
module qts_checker #(
  parameter int unsigned CMP_W = 6,
  localparam int unsigned LVL = CMP_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [CMP_W-1:0] thermo_in,
  input logic             guard_lo,
  input logic             guard_hi,
  input logic             sin_en,
  input logic             cos_en,
  input logic             err_clr,
  input logic [LVL-1:0]   a_level,
  input logic             a_valid,
  input logic [LVL-1:0]   b_level,
  input logic             b_valid,
  input logic             range_err
);
  logic [CMP_W:0] ext;
  logic           legal;
  logic           oor;

  assign ext   = {1'b0, thermo_in};
  assign legal = ((ext + 1'b1) & ext) == '0;
  assign oor   = (sin_en || cos_en) && (guard_hi || !guard_lo);

  // R2
  a_pulse_chk: assert property (@(posedge clk) disable iff (rst) sin_en |=> a_valid);
  // R4
  a_quiet_chk: assert property (@(posedge clk) disable iff (rst) !sin_en |=> (!a_valid && $stable(a_level)));
  // R3
  b_pulse_chk: assert property (@(posedge clk) disable iff (rst) cos_en |=> b_valid);
  // R4
  b_quiet_chk: assert property (@(posedge clk) disable iff (rst) !cos_en |=> (!b_valid && $stable(b_level)));
  // R1
  a_onehot_chk: assert property (@(posedge clk) disable iff (rst) (sin_en && legal) |=> ($countones(a_level) == 1));
  // R1
  b_onehot_chk: assert property (@(posedge clk) disable iff (rst) (cos_en && legal) |=> ($countones(b_level) == 1));
  // R7
  range_set_chk: assert property (@(posedge clk) disable iff (rst) oor |=> range_err);
  // R8
  range_hold_chk: assert property (@(posedge clk) disable iff (rst) (range_err && !err_clr) |=> range_err);
  // R9
  range_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(range_err) |-> $past(oor));
endmodule

bind quad_thermo_sampler qts_checker #(.CMP_W(CMP_W)) i_qts_checker (
  .clk       (clk),
  .rst       (rst),
  .thermo_in (thermo_in),
  .guard_lo  (guard_lo),
  .guard_hi  (guard_hi),
  .sin_en    (sin_en),
  .cos_en    (cos_en),
  .err_clr   (err_clr),
  .a_level   (a_level),
  .a_valid   (a_valid),
  .b_level   (b_level),
  .b_valid   (b_valid),
  .range_err (range_err)
);

// File: tb/test_quad_thermo_sampler.sv
`timescale 1ns/1ps
module test_quad_thermo_sampler;
  localparam int CW = 6;
  localparam int LV = CW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] thermo_in = '0;
  logic guard_lo = 1'b1, guard_hi = 1'b0;
  logic sin_en = 1'b0, cos_en = 1'b0, err_clr = 1'b0;
  logic [LV-1:0] a_level, b_level;
  logic a_valid, b_valid, range_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [LV-1:0] e_a, e_b;
  logic e_av, e_bv, e_err;

  always #2.5 clk = ~clk;

  quad_thermo_sampler i_quad_thermo_sampler (
    .clk(clk), .rst(rst), .thermo_in(thermo_in), .guard_lo(guard_lo),
    .guard_hi(guard_hi), .sin_en(sin_en), .cos_en(cos_en), .err_clr(err_clr),
    .a_level(a_level), .a_valid(a_valid), .b_level(b_level), .b_valid(b_valid),
    .range_err(range_err)
  );

  // R1 and R6: bit k = t[k] ^ t[k-1], padding t[-1]=1, t[CW]=0
  function automatic logic [LV-1:0] exp_level(input logic [CW-1:0] t);
    logic [LV-1:0] r;
    for (int k = 0; k < LV; k++) begin
      logic lo, hi;
      lo = (k == 0) ? 1'b1 : t[k-1];
      hi = (k == CW) ? 1'b0 : t[k];
      r[k] = lo ^ hi;
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] therm_n(input int n);
    return CW'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(a_level == e_a, {req, " a_level"}, 32'(a_level), 32'(e_a));
    chk(a_valid == e_av, {req, " a_valid"}, 32'(a_valid), 32'(e_av));
    chk(b_level == e_b, {req, " b_level"}, 32'(b_level), 32'(e_b));
    chk(b_valid == e_bv, {req, " b_valid"}, 32'(b_valid), 32'(e_bv));
    chk(range_err == e_err, {req, " range_err"}, 32'(range_err), 32'(e_err));
  endtask

  task automatic step(input logic [CW-1:0] t, input logic s, input logic c,
                      input logic gl, input logic gh, input logic clr, input string req);
    logic [LV-1:0] cv;
    thermo_in = t; sin_en = s; cos_en = c;
    guard_lo = gl; guard_hi = gh; err_clr = clr;
    cv = exp_level(t);
    @(posedge clk);
    e_av = s; e_bv = c;
    if (s) e_a = cv;
    if (c) e_b = cv;
    if ((s || c) && (gh || !gl)) e_err = 1'b1;
    else if (clr) e_err = 1'b0;
    #1;
    check_all(req);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    e_a = 7'b0001000; e_b = 7'b0001000; e_av = 0; e_bv = 0; e_err = 0;
    // R5 reset state
    check_all("R5");

    // R1/R2: every level on stream A, including both extremes
    for (int n = 0; n <= CW; n++) step(therm_n(n), 1, 0, 1, 0, 0, "R1 R2");
    // R1/R3: every level on stream B
    for (int n = CW; n >= 0; n--) step(therm_n(n), 0, 1, 1, 0, 0, "R1 R3");
    // R3: both enables on one edge
    step(therm_n(2), 1, 1, 1, 0, 0, "R3 both");
    // R4: hold with no enables while the input changes
    step(therm_n(5), 0, 0, 1, 0, 0, "R4 hold");
    step(therm_n(0), 0, 0, 1, 0, 0, "R4 hold");
    // R6: bubbled codes
    step(6'b000101, 1, 0, 1, 0, 0, "R6 bubble");
    step(6'b110110, 0, 1, 1, 0, 0, "R6 bubble");
    // R9: guards out of range without an enable
    step(therm_n(3), 0, 0, 0, 1, 0, "R9 ignore");
    // R7: top guard and bottom guard on captures
    step(therm_n(6), 1, 0, 1, 1, 0, "R7 top");
    step(therm_n(3), 0, 0, 1, 0, 0, "R8 sticky");
    step(therm_n(3), 0, 0, 1, 0, 1, "R8 clear");
    step(therm_n(0), 0, 1, 0, 0, 0, "R7 bottom");
    // R8: new event with a clear keeps the flag
    step(therm_n(0), 1, 0, 0, 0, 1, "R8 event beats clear");
    step(therm_n(3), 0, 0, 1, 0, 1, "R8 clear");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [CW-1:0] t;
      logic gl, gh;
      if ($urandom % 4 != 0) t = therm_n(int'($urandom % (CW + 1)));
      else t = CW'($urandom);
      gl = ($urandom % 10) != 0;
      gh = ($urandom % 10) == 0;
      step(t, 1'($urandom), 1'($urandom), gl, gh, ($urandom % 8) == 0, "R1 R2 R3 R6 R7 R8 random");
    end

    // R5: reset mid-run restores the idle state
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    e_a = 7'b0001000; e_b = 7'b0001000; e_av = 0; e_bv = 0; e_err = 0;
    check_all("R5 rerun");
    summary();
  end
endmodule